// File: doc/BRIEF.md
# Blowfish Round Engine with RAM-Held S-Boxes

This block runs the Feistel rounds of the Blowfish cipher on a 64-bit block held as two 32-bit halves. The four 256-word substitution tables are kept in two dual-port synchronous RAMs, two tables per RAM, with no duplicate copies. The 18-word subkey array is kept in a small register file. Both are loaded through a single write port while the engine is idle.

A start strobe captures the two input halves and a round count. Each round takes four clocks. The first pair of table reads is issued in the first clock. The second pair is issued in the next clock, while the first two results are added. The third clock folds in the second pair, and the fourth clock updates and swaps the halves. One further clock applies the closing subkey whitening, registers the result and raises a one-cycle completion pulse.

Key expansion and any outer repetition loop belong to the surrounding logic.

Top module: `bf_round_engine`

## Requirements
- R1: For an effective round count n, the result equals the following computation. For i = 0..n-1: set L ^= P[i], then R ^= F(L), then swap L and R. Afterwards, out_l = R ^ P[n+1] and out_r = L ^ P[n]. Here F(x) = ((S0[x[31:24]] + S1[x[23:16]]) ^ S2[x[15:8]]) + S3[x[7:0]], with every sum taken modulo 2^32.
- R2: rounds_i sets n for values 1..16. A value of 0 or any value above 16 runs 16 rounds.
- R3: done_o rises 4n+1 clock edges after the edge that samples start_i.
- R4: done_o is high for exactly one cycle per run.
- R5: l_o and r_o change only on the cycle in which done_o is raised. Otherwise they hold their value.
- R6: Table writes presented while a run is in progress have no effect on any table.
- R7: start_i asserted while a run is in progress is ignored. The current run completes with its own inputs and timing.
- R8: After reset, l_o, r_o and done_o are all zero.
- R9: wr_tbl_i values 0..3 write S-box 0..3 at wr_addr_i. Value 4 writes the subkey array, and only for addresses 0..17. Values 5..7, and subkey addresses of 18 or more, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (sampled when idle) |
| l_i | input | 32 | Initial left half |
| r_i | input | 32 | Initial right half |
| rounds_i | input | 5 | Requested round count |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 3 | Table select: 0..3 S-box, 4 subkeys |
| wr_addr_i | input | 8 | Entry index within the selected table |
| wr_data_i | input | 32 | Word to write |
| l_o | output | 32 | Final left half |
| r_o | output | 32 | Final right half |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of functions can collide in the same cycle. A table write can arrive while the rounds are reading the RAMs, and a new start can arrive while a run is still going. The bench provokes the first by writing subkey 0 and the exact S0 entry that the next run will index, both in the middle of a run. It then judges the current run and the following run against a model that never saw those writes. The bench provokes the second by pulsing start with different halves and a count of 1 in the middle of a 16-round run. It requires the original result, and done exactly 65 edges after the first start.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} bf_state_t;
  // table select codes: 0..3 address an S-box, this one the subkey array
  localparam logic [2:0] TBL_SUBKEY = 3'd4;
endpackage

// File: rtl/bf_sbox_pair_ram.sv
// Two S-boxes in one memory: the top address bit selects the table.
// One write port, two registered read ports sharing a read enable.
module bf_sbox_pair_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] qa,
  output logic [DW-1:0] qb
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) begin
      qa <= mem[ra];
      qb <= mem[rb];
    end
  end
endmodule

// File: rtl/bf_parray_regs.sv
// Subkey register file with three combinational read ports.
module bf_parray_regs #(
  parameter int N  = 18,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  localparam int IW = $clog2(N);
  localparam logic [AW-1:0] LIMIT = AW'(N);

  logic [DW-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (waddr < LIMIT)) begin
      regs[waddr[IW-1:0]] <= wdata;
    end
  end

  always_comb begin
    rd0 = (ra0 < LIMIT) ? regs[ra0[IW-1:0]] : '0;
    rd1 = (ra1 < LIMIT) ? regs[ra1[IW-1:0]] : '0;
    rd2 = (ra2 < LIMIT) ? regs[ra2[IW-1:0]] : '0;
  end

  // a write to a valid index is visible on a matching read port next cycle
  assert_subkey_write_R9: assert property (@(posedge clk) disable iff (rst)
    (we && (waddr < LIMIT)) |=> ((ra0 != $past(waddr)) || (rd0 == $past(wdata))));
endmodule

// File: rtl/bf_round_engine.sv
module bf_round_engine
  import bf_pkg::*;
#(
  parameter int SBOX_AW    = 8,   // 2**SBOX_AW entries per S-box; word = 4 bytes
  parameter int MAX_ROUNDS = 16   // MAX_ROUNDS+2 must not exceed 2**SBOX_AW
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic [4*SBOX_AW-1:0]              l_i,
  input  logic [4*SBOX_AW-1:0]              r_i,
  input  logic [$clog2(MAX_ROUNDS+1)-1:0]   rounds_i,
  input  logic                              wr_en_i,
  input  logic [2:0]                        wr_tbl_i,
  input  logic [SBOX_AW-1:0]                wr_addr_i,
  input  logic [4*SBOX_AW-1:0]              wr_data_i,
  output logic [4*SBOX_AW-1:0]              l_o,
  output logic [4*SBOX_AW-1:0]              r_o,
  output logic                              done_o
);
  localparam int W      = 4 * SBOX_AW;
  localparam int P_N    = MAX_ROUNDS + 2;
  localparam int CNT_W  = $clog2(MAX_ROUNDS + 1);
  localparam int RAM_AW = SBOX_AW + 1;
  localparam int N_RAM  = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ROUNDS);

  bf_state_t        st;
  logic [1:0]       phase;
  logic [CNT_W-1:0] rnd, nr_eff, nr_req;
  logic [W-1:0]     xl, xr, sum_q, f_q, t_cur;
  logic [W-1:0]     p_cur, p_lo, p_hi;
  logic             idle;

  logic              ram_we [N_RAM];
  logic              ram_re [N_RAM];
  logic [RAM_AW-1:0] ram_ra [N_RAM];
  logic [RAM_AW-1:0] ram_rb [N_RAM];
  logic [W-1:0]      ram_qa [N_RAM];
  logic [W-1:0]      ram_qb [N_RAM];

  assign idle   = (st == ST_IDLE);
  assign t_cur  = xl ^ p_cur;
  assign nr_req = ((rounds_i == '0) || (rounds_i > CNT_MAX)) ? CNT_MAX : rounds_i;

  // subkey storage
  bf_parray_regs #(.N(P_N), .DW(W), .AW(SBOX_AW)) u_pkeys (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en_i && idle && (wr_tbl_i == TBL_SUBKEY)),
    .waddr (wr_addr_i),
    .wdata (wr_data_i),
    .ra0   (SBOX_AW'(rnd)),
    .ra1   (SBOX_AW'(nr_eff)),
    .ra2   (SBOX_AW'(nr_eff) + SBOX_AW'(1)),
    .rd0   (p_cur),
    .rd1   (p_lo),
    .rd2   (p_hi)
  );

  // read schedule: RAM 0 (S0,S1) in phase 0 from t; RAM 1 (S2,S3) in phase 1
  always_comb begin
    ram_re[0] = (st == ST_RUN) && (phase == 2'd0);
    ram_ra[0] = {1'b0, t_cur[4*SBOX_AW-1 -: SBOX_AW]};
    ram_rb[0] = {1'b1, t_cur[3*SBOX_AW-1 -: SBOX_AW]};
    ram_re[1] = (st == ST_RUN) && (phase == 2'd1);
    ram_ra[1] = {1'b0, xl[2*SBOX_AW-1 -: SBOX_AW]};
    ram_rb[1] = {1'b1, xl[SBOX_AW-1:0]};
  end

  for (genvar g = 0; g < N_RAM; g++) begin : g_sram
    assign ram_we[g] = wr_en_i && idle && !wr_tbl_i[2] && (wr_tbl_i[1] == 1'(g));
    bf_sbox_pair_ram #(.AW(RAM_AW), .DW(W)) u_ram (
      .clk   (clk),
      .we    (ram_we[g]),
      .waddr ({wr_tbl_i[0], wr_addr_i}),
      .wdata (wr_data_i),
      .re    (ram_re[g]),
      .ra    (ram_ra[g]),
      .rb    (ram_rb[g]),
      .qa    (ram_qa[g]),
      .qb    (ram_qb[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      phase  <= '0;
      rnd    <= '0;
      nr_eff <= CNT_W'(1);
      xl     <= '0;
      xr     <= '0;
      sum_q  <= '0;
      f_q    <= '0;
      l_o    <= '0;
      r_o    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            xl     <= l_i;
            xr     <= r_i;
            nr_eff <= nr_req;
            rnd    <= '0;
            phase  <= '0;
            st     <= ST_RUN;
          end
        end
        ST_RUN: begin
          phase <= phase + 2'd1;
          case (phase)
            2'd0: xl    <= t_cur;
            2'd1: sum_q <= ram_qa[0] + ram_qb[0];
            2'd2: f_q   <= (sum_q ^ ram_qa[1]) + ram_qb[1];
            default: begin
              xl <= xr ^ f_q;
              xr <= xl;
              if (rnd == nr_eff - CNT_W'(1)) st <= ST_FIN;
              else rnd <= rnd + CNT_W'(1);
            end
          endcase
        end
        ST_FIN: begin
          l_o    <= xr ^ p_hi;
          r_o    <= xl ^ p_lo;
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(l_o) && $stable(r_o)));

  assert_phase_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && phase == 2'd3 && rnd != nr_eff - CNT_W'(1)) |=> (st == ST_RUN && phase == 2'd0));

  assert_round_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (rnd < nr_eff && nr_eff != '0 && nr_eff <= CNT_MAX));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && start_i) |=> $stable(nr_eff));

  assert_done_after_fin_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($past(st) == ST_FIN));
endmodule

// File: tb/bf_round_engine_test.sv
module bf_round_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] l_i = '0, r_i = '0;
  logic [4:0]  rounds_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_tbl_i = '0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] l_o, r_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] sm [4][256];
  logic [31:0] pm [18];

  always #10 clk = ~clk;

  bf_round_engine uut (
    .clk(clk), .rst(rst), .start_i(start_i), .l_i(l_i), .r_i(r_i),
    .rounds_i(rounds_i), .wr_en_i(wr_en_i), .wr_tbl_i(wr_tbl_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .l_o(l_o), .r_o(r_o), .done_o(done_o)
  );

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  function automatic logic [63:0] model(input logic [31:0] li, ri, input int n);
    logic [31:0] l = li, r = ri, f, tmp;
    for (int i = 0; i < n; i++) begin
      l = l ^ pm[i];
      f = ((sm[0][l[31:24]] + sm[1][l[23:16]]) ^ sm[2][l[15:8]]) + sm[3][l[7:0]];
      r = r ^ f;
      tmp = l; l = r; r = tmp;
    end
    return {r ^ pm[n+1], l ^ pm[n]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] tbl, input logic [7:0] addr, input logic [31:0] data);
    wr_en_i = 1'b1; wr_tbl_i = tbl; wr_addr_i = addr; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_start(input logic [31:0] li, ri, input logic [4:0] n);
    start_i = 1'b1; l_i = li; r_i = ri; rounds_i = n;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(inout int k);
    do begin
      @(negedge clk);
      k++;
    end while (!done_o && k < 400);
  endtask

  // start a run, check latency (R3), result and single-cycle pulse (R4)
  task automatic run_check(input logic [31:0] li, ri, input logic [4:0] n, input int neff, input string req);
    int k = 0;
    pulse_start(li, ri, n);
    wait_done(k);
    chk("R3 latency", 64'(k), 64'(4 * neff + 1));
    chk(req, {l_o, r_o}, model(li, ri, neff));
    @(negedge clk);
    chk("R4 done pulse", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    chk("R8 reset outputs", {l_o, r_o}, 64'd0);
    chk("R8 reset done", 64'(done_o), 64'd0);
  endtask

  task automatic t_load();
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 256; a++) begin
        sm[t][a] = next_rand();
        wr(3'(t), 8'(a), sm[t][a]);
      end
    for (int i = 0; i < 18; i++) begin
      pm[i] = next_rand();
      wr(3'd4, 8'(i), pm[i]);
    end
  endtask

  task automatic t_full();
    run_check(32'h0123_4567, 32'h89ab_cdef, 5'd16, 16, "R1 full rounds pattern A");
    run_check(32'h0000_0000, 32'h0000_0000, 5'd16, 16, "R1 full rounds zero block");
    run_check(32'hffff_ffff, 32'h5a5a_a5a5, 5'd16, 16, "R1 full rounds pattern C");
  endtask

  task automatic t_counts();
    run_check(32'hdead_beef, 32'hcafe_f00d, 5'd1, 1, "R2 one round");
    run_check(32'h1357_9bdf, 32'h2468_ace0, 5'd5, 5, "R2 five rounds");
    run_check(32'h0f0f_0f0f, 32'hf0f0_f0f0, 5'd0, 16, "R2 zero means sixteen");
    run_check(32'h7777_1111, 32'h2222_8888, 5'd20, 16, "R2 above max clamps");
  endtask

  task automatic t_hold();
    logic [63:0] snap = {l_o, r_o};
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if ({l_o, r_o} !== snap) bad++;
    end
    chk("R5 result holds while idle", 64'(bad), 64'd0);
  endtask

  task automatic t_write_busy();
    logic [31:0] nl = 32'h3c3c_9696;
    logic [31:0] tv = nl ^ pm[0];
    logic [63:0] exp_a;
    int k = 0;
    exp_a = model(32'habcd_0123, 32'h4567_89ab, 16);
    pulse_start(32'habcd_0123, 32'h4567_89ab, 5'd16);
    repeat (6) begin @(negedge clk); k++; end
    wr(3'd0, tv[31:24], ~sm[0][tv[31:24]]); k++;
    wr(3'd4, 8'd0, ~pm[0]); k++;
    wr(3'd3, 8'h00, ~sm[3][0]); k++;
    wait_done(k);
    chk("R6 run with writes during busy", {l_o, r_o}, exp_a);
    @(negedge clk);
    run_check(nl, 32'h6969_c3c3, 5'd16, 16, "R6 tables untouched after busy writes");
  endtask

  task automatic t_start_busy();
    logic [63:0] exp_a;
    int k = 0;
    exp_a = model(32'h0bad_cafe, 32'hfeed_face, 16);
    pulse_start(32'h0bad_cafe, 32'hfeed_face, 5'd16);
    repeat (8) begin @(negedge clk); k++; end
    pulse_start(32'h1111_2222, 32'h3333_4444, 5'd1); k++;
    wait_done(k);
    chk("R7 start during run latency", 64'(k), 64'd65);
    chk("R7 start during run result", {l_o, r_o}, exp_a);
    @(negedge clk);
  endtask

  task automatic t_bad_select();
    logic [31:0] nl = 32'h5555_aaaa;
    logic [31:0] tv = nl ^ pm[0];
    wr(3'd5, tv[31:24], 32'h0);
    wr(3'd6, tv[23:16], 32'h0);
    wr(3'd7, tv[23:16], 32'h0);
    wr(3'd4, 8'd18, 32'hffff_ffff);
    wr(3'd4, 8'd255, 32'hffff_ffff);
    run_check(nl, 32'haaaa_5555, 5'd16, 16, "R9 unused selects and subkey range");
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_full();
    t_counts();
    t_hold();
    t_write_busy();
    t_start_busy();
    t_bad_select();
    finish_up();
  end
endmodule